// File: doc/BRIEF.md
# NAND Page Read Controller with Per-Chunk ECC Hand-off

This block reads one page of an 8-bit NAND device: the main area followed by the spare area. It sends its command and address bytes through a strobed byte port. It waits for the device to report ready, then pulls data bytes one at a time with a read strobe. The main area is split into equal chunks. Before each chunk the block pulses a restart to an external ECC accumulator. It streams every main byte out on a valid/data pair, and it latches the accumulator's 24-bit result once the chunk's last byte has been absorbed.

After the main area, the block reads the spare area in the same stream. It picks out the stored ECC bytes at fixed spare offsets and checks spare byte 0 for the bad-block marker. It then releases chip enable. Only after that does it present each chunk's computed and stored ECC to an external checker, one chunk per cycle, and record the checker's 2-bit verdict. A probe mode reads only the spare area of the first page of the block that holds the requested page. This is done before a block is read, to decide whether to skip it. A one-cycle done pulse ends every operation, with per-chunk status and the bad-block flag held until the next start.

Top module: `nand_page_reader`

## Requirements
- R1: Each operation issues exactly six byte strobes on `nand_we`, in this order: command 0x00 with `nand_cle`, column low byte, column high byte, row low byte and row high byte with `nand_ale`, then command 0x30 with `nand_cle`. `nand_cle` and `nand_ale` are never high together.
- R2: After the confirm command, no `nand_re` strobe occurs while `nand_rb` is low. The first strobe comes at least `wait_cycles`+2 cycles after the first cycle in which `nand_rb` is seen high again.
- R3: Consecutive `nand_re` strobes are at least `gap_cycles`+1 cycles apart, and exactly that far apart within a chunk.
- R4: In a page read, every main-area byte appears once on `data_valid`/`data_byte`, in device order. `ecc_restart` pulses once before each chunk (main bytes divided by chunk size), never in the same cycle as `data_valid`.
- R5: The ECC presented for chunk k on `cmp_calc` is the accumulator value after the last byte of chunk k and before the next restart.
- R6: The stored ECC for chunk k is spare bytes 1+3k, 2+3k and 3+3k. The first of these is in bits 7:0 of `cmp_stored`, the last in bits 23:16.
- R7: With `probe` high, the column sent is the main-area size. The row sent is the requested row with its low log2(pages per block) bits cleared. Only the spare area is strobed, no `data_valid` or `ecc_restart` occurs, and no chunk is presented.
- R8: `bad_block` is 1 after an operation whose spare byte 0 was not 0xFF, and 0 otherwise.
- R9: `nand_ce_n` is high whenever `cmp_valid` is high, and low whenever `nand_re` is high.
- R10: After a page read, `cmp_valid` presents chunks 0 to 3 in order. `chunk_status` bits 2k+1:2k hold the `cmp_verdict` given for chunk k (0 clean, 1 corrected, 2 ECC field error, 3 uncorrectable). `done` is high for one cycle. After a probe, `chunk_status` is 0.
- R11: A `start` while an operation is in progress has no effect: no extra strobes are issued and only one `done` pulse follows.
- R12: After reset, `done`, `nand_re`, `nand_we`, `data_valid` and `chunk_status` are 0, and `nand_ce_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| probe | input | 1 | 1: spare-only bad-block probe, 0: full page read |
| row_addr | input | 8*ROW_CYC | Page (row) address |
| wait_cycles | input | CNT_W | Extra cycles after ready before the first read strobe |
| gap_cycles | input | CNT_W | Idle cycles between read strobes |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Byte on `nand_io_out` is a command |
| nand_ale | output | 1 | Byte on `nand_io_out` is an address |
| nand_we | output | 1 | Write strobe for command/address byte |
| nand_io_out | output | 8 | Command/address byte |
| nand_rb | input | 1 | Device ready (1) / busy (0) |
| nand_re | output | 1 | Read strobe; byte sampled at the end of the cycle |
| nand_io_in | input | 8 | Byte from the device |
| data_valid | output | 1 | Main-area byte valid |
| data_byte | output | 8 | Main-area byte |
| ecc_restart | output | 1 | Clear the external accumulator |
| ecc_calc | input | 24 | External accumulator value |
| cmp_valid | output | 1 | Chunk ECC pair presented to the checker |
| cmp_idx | output | $clog2(NCH) | Chunk being presented |
| cmp_calc | output | 24 | Computed ECC of that chunk |
| cmp_stored | output | 24 | Stored ECC of that chunk |
| cmp_verdict | input | 2 | Checker verdict for the presented chunk |
| done | output | 1 | One-cycle end-of-operation pulse |
| chunk_status | output | 2*NCH | Per-chunk verdicts of the last page read |
| bad_block | output | 1 | Spare byte 0 was not 0xFF |

## Verification
The bench builds the block with a 256-byte main area, 64-byte chunks and a 16-byte spare area. This keeps four chunks per page and twelve stored ECC bytes, while a page takes a few hundred strobes, so many reads fit in the run. A device model answers the confirm command with a busy period of random length. The bench sweeps wait and gap settings from 0 up to values past the two fixed cycles at a chunk boundary. This exercises both the restart spacing and the pause path. Probes with good and bad markers, a page read with a bad marker, and a start issued mid-operation cover the remaining modes.

// File: rtl/nand_page_reader_pkg.sv
package nand_page_reader_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD0,
        ST_ADDR,
        ST_CMD1,
        ST_WAITRB,
        ST_PAUSE,
        ST_CLR,
        ST_READ,
        ST_GAP,
        ST_DRAIN,
        ST_CMP,
        ST_FIN
    } rd_state_e;

    localparam logic [7:0] OP_READ_SETUP = 8'h00;
    localparam logic [7:0] OP_READ_GO    = 8'h30;

endpackage

// File: rtl/nand_addr_byte.sv
module nand_addr_byte #(
    parameter int ROW_CYC    = 2,
    parameter int MAIN_BYTES = 2048,
    parameter int AI_W       = 2
) (
    input  logic [AI_W-1:0]      idx,
    input  logic [8*ROW_CYC-1:0] row,
    input  logic                 spare_col,
    output logic [7:0]           byte_o
);
    logic [15:0] col;

    always_comb begin
        col    = spare_col ? 16'(MAIN_BYTES) : 16'h0000;
        byte_o = col[7:0];
        if (idx == AI_W'(1)) byte_o = col[15:8];
        for (int r = 0; r < ROW_CYC; r++) begin
            if (idx == AI_W'(r + 2)) byte_o = row[8*r +: 8];
        end
    end
endmodule

// File: rtl/nand_spare_grab.sv
module nand_spare_grab #(
    parameter int NCH     = 4,
    parameter int ECC_OFS = 1,
    parameter int SI_W    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cap,
    input  logic [SI_W-1:0]   sidx,
    input  logic [7:0]        sbyte,
    output logic [NCH*24-1:0] stored,
    output logic              bad
);
    logic [NCH*24-1:0] stored_d, stored_q;
    logic              bad_d, bad_q;

    always_comb begin
        stored_d = stored_q;
        bad_d    = bad_q;
        if (clr) begin
            stored_d = '0;
            bad_d    = 1'b0;
        end else if (cap) begin
            if (sidx == '0) bad_d = (sbyte != 8'hFF);
            for (int k = 0; k < NCH; k++) begin
                for (int j = 0; j < 3; j++) begin
                    if (sidx == SI_W'(ECC_OFS + 3*k + j)) stored_d[24*k + 8*j +: 8] = sbyte;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stored_q <= '0;
            bad_q    <= 1'b0;
        end else begin
            stored_q <= stored_d;
            bad_q    <= bad_d;
        end
    end

    assign stored = stored_q;
    assign bad    = bad_q;
endmodule

// File: rtl/nand_page_reader.sv
module nand_page_reader
    import nand_page_reader_pkg::*;
#(
    parameter int MAIN_BYTES    = 2048,
    parameter int CHUNK_BYTES   = 512,
    parameter int SPARE_BYTES   = 64,
    parameter int ECC_OFS       = 1,
    parameter int ROW_CYC       = 2,
    parameter int PAGES_PER_BLK = 64,
    parameter int CNT_W         = 16,
    localparam int NCH   = MAIN_BYTES / CHUNK_BYTES,
    localparam int ROW_W = 8 * ROW_CYC,
    localparam int CI_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              probe,
    input  logic [ROW_W-1:0]  row_addr,
    input  logic [CNT_W-1:0]  wait_cycles,
    input  logic [CNT_W-1:0]  gap_cycles,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we,
    output logic [7:0]        nand_io_out,
    input  logic              nand_rb,
    output logic              nand_re,
    input  logic [7:0]        nand_io_in,
    output logic              data_valid,
    output logic [7:0]        data_byte,
    output logic              ecc_restart,
    input  logic [23:0]       ecc_calc,
    output logic              cmp_valid,
    output logic [CI_W-1:0]   cmp_idx,
    output logic [23:0]       cmp_calc,
    output logic [23:0]       cmp_stored,
    input  logic [1:0]        cmp_verdict,
    output logic              done,
    output logic [2*NCH-1:0]  chunk_status,
    output logic              bad_block
);
    localparam int NADDR = 2 + ROW_CYC;
    localparam int AI_W  = $clog2(NADDR);
    localparam int IDX_W = $clog2(MAIN_BYTES + 1);
    localparam int CH_W  = $clog2(NCH + 1);

    typedef struct packed {
        rd_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  bidx;
        logic [CH_W-1:0]   chunk;
        logic              spare;
        logic              probe;
        logic [ROW_W-1:0]  row;
        logic              dv;
        logic [7:0]        dbyte;
        logic [NCH*24-1:0] calc;
        logic [2*NCH-1:0]  stat;
    } rd_regs_t;

    rd_regs_t          q, d;
    logic              grab_clr, grab_cap, grab_bad;
    logic [NCH*24-1:0] grab_stored;
    logic [7:0]        addr_byte;
    logic [IDX_W-1:0]  in_chunk;

    assign in_chunk = q.bidx % IDX_W'(CHUNK_BYTES);

    always_comb begin
        d        = q;
        d.dv     = 1'b0;
        grab_clr = 1'b0;
        grab_cap = 1'b0;
        case (q.st)
            ST_IDLE: if (start) begin
                d.st    = ST_CMD0;
                d.probe = probe;
                d.row   = probe ? (row_addr & ~ROW_W'(PAGES_PER_BLK - 1)) : row_addr;
                d.stat  = '0;
                d.calc  = '0;
                d.chunk = '0;
                d.spare = 1'b0;
                d.bidx  = '0;
                d.cnt   = '0;
                grab_clr = 1'b1;
            end
            ST_CMD0: begin
                d.st  = ST_ADDR;
                d.cnt = '0;
            end
            ST_ADDR: begin
                if (q.cnt == CNT_W'(NADDR - 1)) d.st = ST_CMD1;
                else d.cnt = q.cnt + 1'b1;
            end
            ST_CMD1: d.st = ST_WAITRB;
            ST_WAITRB: if (nand_rb) begin
                d.st  = ST_PAUSE;
                d.cnt = '0;
            end
            ST_PAUSE: begin
                if (q.cnt >= wait_cycles) begin
                    if (q.probe) begin
                        d.st    = ST_READ;
                        d.spare = 1'b1;
                    end else begin
                        d.st = ST_CLR;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_CLR: begin
                for (int k = 0; k < NCH; k++) begin
                    if (q.chunk == CH_W'(k + 1)) d.calc[24*k +: 24] = ecc_calc;
                end
                if (q.chunk == CH_W'(NCH)) begin
                    d.spare = 1'b1;
                    d.bidx  = '0;
                end
                if (gap_cycles > CNT_W'(2)) begin
                    d.st  = ST_GAP;
                    d.cnt = CNT_W'(3);
                end else begin
                    d.st = ST_READ;
                end
            end
            ST_READ: begin
                d.bidx = q.bidx + 1'b1;
                if (!q.spare) begin
                    d.dv    = 1'b1;
                    d.dbyte = nand_io_in;
                end else begin
                    grab_cap = 1'b1;
                end
                if (!q.spare && in_chunk == IDX_W'(CHUNK_BYTES - 1)) begin
                    d.chunk = q.chunk + 1'b1;
                    d.st    = ST_DRAIN;
                end else if (q.spare && q.bidx == IDX_W'(SPARE_BYTES - 1)) begin
                    d.cnt = '0;
                    d.st  = q.probe ? ST_FIN : ST_CMP;
                end else if (gap_cycles != '0) begin
                    d.st  = ST_GAP;
                    d.cnt = CNT_W'(1);
                end else begin
                    d.st = ST_READ;
                end
            end
            ST_GAP: begin
                if (q.cnt >= gap_cycles) d.st = ST_READ;
                else d.cnt = q.cnt + 1'b1;
            end
            ST_DRAIN: d.st = ST_CLR;
            ST_CMP: begin
                for (int k = 0; k < NCH; k++) begin
                    if (q.cnt == CNT_W'(k)) d.stat[2*k +: 2] = cmp_verdict;
                end
                if (q.cnt == CNT_W'(NCH - 1)) d.st = ST_FIN;
                else d.cnt = q.cnt + 1'b1;
            end
            ST_FIN: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    nand_addr_byte #(.ROW_CYC(ROW_CYC), .MAIN_BYTES(MAIN_BYTES), .AI_W(AI_W)) i_addr (
        .idx(q.cnt[AI_W-1:0]), .row(q.row), .spare_col(q.probe), .byte_o(addr_byte)
    );

    nand_spare_grab #(.NCH(NCH), .ECC_OFS(ECC_OFS), .SI_W(IDX_W)) i_grab (
        .clk(clk), .rst_n(rst_n), .clr(grab_clr), .cap(grab_cap), .sidx(q.bidx),
        .sbyte(nand_io_in), .stored(grab_stored), .bad(grab_bad)
    );

    always_comb begin
        cmp_calc   = q.calc[23:0];
        cmp_stored = grab_stored[23:0];
        for (int k = 0; k < NCH; k++) begin
            if (q.cnt == CNT_W'(k)) begin
                cmp_calc   = q.calc[24*k +: 24];
                cmp_stored = grab_stored[24*k +: 24];
            end
        end
    end

    assign nand_ce_n    = (q.st == ST_IDLE) || (q.st == ST_CMP) || (q.st == ST_FIN);
    assign nand_cle     = (q.st == ST_CMD0) || (q.st == ST_CMD1);
    assign nand_ale     = (q.st == ST_ADDR);
    assign nand_we      = nand_cle || nand_ale;
    assign nand_io_out  = (q.st == ST_CMD0) ? OP_READ_SETUP :
                          (q.st == ST_CMD1) ? OP_READ_GO : addr_byte;
    assign nand_re      = (q.st == ST_READ);
    assign data_valid   = q.dv;
    assign data_byte    = q.dbyte;
    assign ecc_restart  = (q.st == ST_CLR) && (q.chunk != CH_W'(NCH));
    assign cmp_valid    = (q.st == ST_CMP);
    assign cmp_idx      = q.cnt[CI_W-1:0];
    assign done         = (q.st == ST_FIN);
    assign chunk_status = q.stat;
    assign bad_block    = grab_bad;
endmodule

// File: rtl/nand_page_reader_chk.sv
module nand_page_reader_chk (
    input logic clk,
    input logic rst_n,
    input logic nand_ce_n,
    input logic nand_cle,
    input logic nand_ale,
    input logic nand_re,
    input logic nand_rb,
    input logic data_valid,
    input logic ecc_restart,
    input logic cmp_valid,
    input logic done
);
    // R1
    cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    // R2
    re_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nand_re |-> nand_rb);

    // R4
    restart_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_restart |-> !data_valid);

    // R9
    cmp_ce_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |-> nand_ce_n);

    // R9
    re_ce_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nand_re |-> !nand_ce_n);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind nand_page_reader nand_page_reader_chk u_chk (
    .clk(clk), .rst_n(rst_n), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_re(nand_re), .nand_rb(nand_rb),
    .data_valid(data_valid), .ecc_restart(ecc_restart),
    .cmp_valid(cmp_valid), .done(done)
);

// File: tb/test_nand_page_reader.sv
module test_nand_page_reader;
    localparam int MB  = 256;
    localparam int CB  = 64;
    localparam int SB  = 16;
    localparam int NCH = MB / CB;
    localparam int EO  = 1;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, start, probe;
    logic [15:0] row_addr, wait_cycles, gap_cycles;
    logic nand_ce_n, nand_cle, nand_ale, nand_we, nand_re, nand_rb;
    logic [7:0] nand_io_out, nand_io_in, data_byte;
    logic data_valid, ecc_restart, cmp_valid, done, bad_block;
    logic [23:0] ecc_calc, cmp_calc, cmp_stored;
    logic [1:0] cmp_idx, cmp_verdict;
    logic [2*NCH-1:0] chunk_status;

    nand_page_reader #(.MAIN_BYTES(MB), .CHUNK_BYTES(CB), .SPARE_BYTES(SB), .ECC_OFS(EO),
        .ROW_CYC(2), .PAGES_PER_BLK(64), .CNT_W(16)) i_nand_page_reader (.*);

    // device model
    logic [7:0]  mem [0:MB+SB-1];
    logic [9:0]  cmdlog [0:255];
    int          nlog = 0;
    int          ptr = 0;
    int          busy = 0;
    int          acnt = 0;
    logic [7:0]  col_l = 0, col_h = 0;
    logic [23:0] acc = 0;
    logic [1:0]  vtab [0:NCH-1];

    assign nand_io_in  = (ptr < MB + SB) ? mem[ptr] : 8'hFF;
    assign ecc_calc    = acc;
    assign cmp_verdict = vtab[cmp_idx];

    always @(posedge clk) begin
        if (!rst_n) begin
            nand_rb <= 1'b1;
            busy    <= 0;
        end else begin
            if (nand_we) begin
                cmdlog[nlog[7:0]] <= {nand_cle, nand_ale, nand_io_out};
                nlog <= nlog + 1;
                if (nand_cle && nand_io_out == 8'h00) acnt <= 0;
                if (nand_ale) begin
                    if (acnt == 0) col_l <= nand_io_out;
                    if (acnt == 1) col_h <= nand_io_out;
                    acnt <= acnt + 1;
                end
                if (nand_cle && nand_io_out == 8'h30) begin
                    nand_rb <= 1'b0;
                    busy    <= 3 + int'($urandom % 8);
                    ptr     <= int'({col_h, col_l});
                end
            end else if (!nand_rb) begin
                if (busy == 0) nand_rb <= 1'b1;
                else busy <= busy - 1;
            end
            if (nand_re) ptr <= ptr + 1;
            if (ecc_restart) acc <= 24'h0;
            else if (data_valid) acc <= {acc[22:0], acc[23]} ^ {16'h0, data_byte};
        end
    end

    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_ecc(input int k);
        logic [23:0] a = 24'h0;
        for (int i = 0; i < CB; i++) a = {a[22:0], a[23]} ^ {16'h0, mem[k*CB + i]};
        return a;
    endfunction

    function automatic logic [23:0] exp_st(input int k);
        return {mem[MB+EO+3*k+2], mem[MB+EO+3*k+1], mem[MB+EO+3*k]};
    endfunction

    task automatic run_op(input bit pr, input logic [15:0] row, input int wt, input int gp,
                          input bit bad, input bit extra_start);
        int base, dn, rst_cnt, ncmp, ndone, cyc, t_rb, t_re1, last_re, min_sp, ce_bad;
        bit saw_low;
        logic [7:0]  dstream [0:MB-1];
        logic [23:0] gc [0:NCH-1];
        logic [23:0] gs [0:NCH-1];
        logic [15:0] erow, ecol;
        logic [2*NCH-1:0] estat;
        bit ok;
        for (int i = 0; i < MB + SB; i++) mem[i] = 8'($urandom);
        mem[MB] = bad ? 8'($urandom % 255) : 8'hFF;
        for (int k = 0; k < NCH; k++) vtab[k] = 2'($urandom);
        @(negedge clk);
        probe = pr; row_addr = row; wait_cycles = 16'(wt); gap_cycles = 16'(gp);
        base = nlog; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        dn = 0; rst_cnt = 0; ncmp = 0; ndone = 0; cyc = 0; t_rb = -1; t_re1 = -1;
        last_re = -1; min_sp = 1 << 30; ce_bad = 0; saw_low = 0;
        while (cyc < 20000 && !(ndone > 0 && cyc > 40 && nand_ce_n)) begin
            cyc++;
            if (extra_start && cyc == 20) begin probe = ~pr; start = 1'b1; end
            if (extra_start && cyc == 21) start = 1'b0;
            if (!nand_rb) saw_low = 1;
            if (saw_low && nand_rb && t_rb < 0) t_rb = cyc;
            if (nand_re) begin
                if (t_re1 < 0) t_re1 = cyc;
                if (last_re >= 0 && cyc - last_re < min_sp) min_sp = cyc - last_re;
                last_re = cyc;
            end
            if (data_valid && dn < MB) begin dstream[dn] = data_byte; dn++; end
            else if (data_valid) dn++;
            if (ecc_restart) rst_cnt++;
            if (cmp_valid) begin
                gc[cmp_idx] = cmp_calc; gs[cmp_idx] = cmp_stored;
                if (!nand_ce_n) ce_bad++;
                if (cmp_idx != 2'(ncmp)) ce_bad++;
                ncmp++;
            end
            if (done) ndone++;
            @(negedge clk);
        end
        chk(cyc < 20000, "watchdog", cyc, 20000);
        // R1 / R7 / R11: command and address sequence
        erow = pr ? (row & 16'hFFC0) : row;
        ecol = pr ? 16'(MB) : 16'h0;
        chk(nlog - base == 6, "R1/R11 strobe count", nlog - base, 6);
        ok = (cmdlog[base[7:0]] == {2'b10, 8'h00}) && (cmdlog[8'(base+1)] == {2'b01, ecol[7:0]}) &&
             (cmdlog[8'(base+2)] == {2'b01, ecol[15:8]}) && (cmdlog[8'(base+3)] == {2'b01, erow[7:0]}) &&
             (cmdlog[8'(base+4)] == {2'b01, erow[15:8]}) && (cmdlog[8'(base+5)] == {2'b10, 8'h30});
        chk(ok, pr ? "R7 probe address bytes" : "R1 command sequence", {ecol, erow}, {ecol, erow});
        // R2
        chk(t_rb >= 0 && t_re1 - t_rb >= wt + 2, "R2 wait after ready", t_re1 - t_rb, wt + 2);
        // R3
        chk(min_sp == gp + 1, "R3 strobe gap", min_sp, gp + 1);
        // R4 / R7
        chk(dn == (pr ? 0 : MB), pr ? "R7 no data in probe" : "R4 byte count", dn, pr ? 0 : MB);
        chk(rst_cnt == (pr ? 0 : NCH), pr ? "R7 no restart in probe" : "R4 restart count", rst_cnt, pr ? 0 : NCH);
        if (!pr) begin
            ok = 1;
            for (int i = 0; i < MB; i++) if (dstream[i] != mem[i]) ok = 0;
            chk(ok, "R4 data stream order", dn, MB);
        end
        // R9 / R10
        chk(ncmp == (pr ? 0 : NCH) && ce_bad == 0, "R9/R10 presentation", ncmp, pr ? 0 : NCH);
        if (!pr) begin
            for (int k = 0; k < NCH; k++) begin
                chk(gc[k] == exp_ecc(k), "R5 computed ecc", gc[k], exp_ecc(k));
                chk(gs[k] == exp_st(k), "R6 stored ecc", gs[k], exp_st(k));
            end
        end
        estat = '0;
        if (!pr) for (int k = 0; k < NCH; k++) estat[2*k +: 2] = vtab[k];
        chk(chunk_status == estat, "R10 chunk status", chunk_status, estat);
        chk(ndone == 1, "R10/R11 done pulses", ndone, 1);
        // R8
        chk(bad_block == bad, "R8 bad marker", bad_block, bad);
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; start = 1'b0; probe = 1'b0;
        row_addr = '0; wait_cycles = '0; gap_cycles = '0;
        for (int i = 0; i < MB + SB; i++) mem[i] = 8'hFF;
        for (int k = 0; k < NCH; k++) vtab[k] = 2'd0;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(done == 0 && nand_re == 0 && nand_we == 0 && data_valid == 0 && nand_ce_n == 1,
            "R12 reset outputs", {done, nand_re, nand_we, data_valid, nand_ce_n}, 5'b00001);
        chk(chunk_status == '0, "R12 reset status", chunk_status, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_op(1'b0, 16'h1234, 0, 0, 1'b0, 1'b0);
        run_op(1'b0, 16'h00C7, 5, 3, 1'b0, 1'b0);
        run_op(1'b1, 16'h3A7F, 2, 0, 1'b0, 1'b0);
        run_op(1'b1, 16'h0041, 0, 1, 1'b1, 1'b0);
        run_op(1'b0, 16'hFFFF, 1, 2, 1'b1, 1'b0);
        run_op(1'b0, 16'h8001, 3, 1, 1'b0, 1'b1);
        for (int n = 0; n < 6; n++)
            run_op(1'($urandom), 16'($urandom), int'($urandom % 8), int'($urandom % 5),
                   1'($urandom), 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule